// File: doc/BRIEF.md
# MDIO Management Master with Background Link Polling

This block drives a Clause 22 management bus (MDC clock, bidirectional MDIO data) towards one external PHY. Software programs a 32-bit control word and a separate PHY address word through a simple register port. It starts single read or write frames by setting a start flag and then watches a busy flag until the frame has finished. After a read, the returned 16-bit value sits in the low half of the control word.

When the polling enable is set, the block owns the bus. It reads the PHY's basic status register on its own, back to back, and compares the link-status bit with the last value it latched. On a mismatch it raises a sticky interrupt, which software clears by writing a one. MDC is derived from the block clock, taken to be a 25 MHz reference, through one of eight selectable dividers. The 32-bit all-ones preamble can be left out.

Top module: `mdio_autopoll_master`

## Requirements
- R1: After reset the control word, the PHY address word and the interrupt word all read zero, and `mdc_o`, `mdio_oe` and `irq_o` are low.
- R2: Writing the control word (`reg_addr`=0) with bit 23 (start) set begins a frame. Start and busy (bit 27) both read one until that frame has finished, and then clear together.
- R3: A write frame (bit 21 = 0) drives, MSB first: `01`, `01`, PHY address[4:0], register address (bits 20:16), turnaround `10`, data (bits 15:0). All bits are driven, and MDIO changes only on a falling MDC edge.
- R4: A read frame (bit 21 = 1) drives `01`, `10`, PHY address and register address (14 bits), then releases MDIO for the turnaround and for 16 data bits sampled on rising MDC edges. The value appears in bits 15:0 once start and busy have cleared.
- R5: With bit 22 clear, the frame is preceded by 32 driven ones. With bit 22 set, it begins directly with `01`.
- R6: Clock select bits 26:24, codes 0..7, give an MDC period of 4, 6, 8, 10, 14, 20, 24 and 28 clocks. MDC stays low between frames.
- R7: Every frame uses the PHY address held in bits 20:16 of the PHY address word (`reg_addr`=1).
- R8: While bit 28 (poll enable) is set, the block issues read frames of register 1 continuously without software action, and busy reads one while a poll frame runs.
- R9: A completed poll whose bit 2 differs from the latched link value updates that value (interrupt word bit 1) and sets the sticky interrupt (bit 0, driving `irq_o`). Writing 1 to bit 0 (`reg_addr`=2) clears it, writing 0 has no effect, and a set in the same cycle as a clear wins. The latched link value resets to 0.
- R10: Clearing bit 28 lets a poll frame already in flight finish in full. Busy then drops, and no further frame starts.
- R11: A start written together with bit 28 set is ignored (start reads 0). Any control write made while start reads one is ignored entirely.
- R12: Bits 30 and 29 are stored and read back as written. Bit 31 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (25 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 PHY address, 2 interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| irq_o | output | 1 | Sticky link-change interrupt |

## Verification
The two functions that can fall in the same cycle are the link-change set from a finishing poll frame and a software write-one clear of the interrupt. The bench counts MDC rising edges in its PHY model, changes the link bit it returns during a poll, and times the clear write to land on the clock edge that ends that frame. The interrupt must then still read one, with the new link value latched. A second overlap, a software start written while a poll frame is draining after disable, is covered by the start-implies-busy rule and by the full-length check on the drained frame.

// File: rtl/mdio_ap_pkg.sv
package mdio_ap_pkg;

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 32;
  localparam int HALF_W  = 4;
  localparam int HDR_W   = 14;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_PHY  = 2'd1,
    RA_IRQ  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic              pre_en;
    logic              rd;
    logic [ADDR_W-1:0] phyad;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
    logic [2:0]        csel;
  } frame_req_t;

  function automatic logic [HALF_W-1:0] mdc_half(input logic [2:0] sel);
    logic [HALF_W-1:0] h;
    case (sel)
      3'd0: h = 4'd2;
      3'd1: h = 4'd3;
      3'd2: h = 4'd4;
      3'd3: h = 4'd5;
      3'd4: h = 4'd7;
      3'd5: h = 4'd10;
      3'd6: h = 4'd12;
      default: h = 4'd14;
    endcase
    return h;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_word(input frame_req_t r);
    logic [1:0] op;
    logic [1:0] ta;
    op = r.rd ? 2'b10 : 2'b01;
    ta = r.rd ? 2'b11 : 2'b10;
    return {2'b01, op, r.phyad, r.regad, ta, (r.rd ? {DATA_W{1'b1}} : r.wdata)};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_ap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              wrap;

  assign wrap = en && (cnt_q == half - 1'b1);
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_ap_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  frame_req_t        req,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int TOTAL_MAX = PRE_LEN + FRAME_W;
  localparam int CNT_W     = $clog2(TOTAL_MAX + 1);

  logic              busy_q;
  frame_req_t        cur_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [DATA_W-1:0] shift_q;

  logic              rise, fall;
  logic [CNT_W-1:0]  pre_eff;
  logic [CNT_W-1:0]  fb_full;
  logic [4:0]        fb;
  logic              in_pre;
  logic              last_bit;
  logic              sample;
  logic [FRAME_W-1:0] fw;

  mdio_mdc_gen u_mdc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (busy_q),
    .half (mdc_half(cur_q.csel)),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  assign pre_eff  = cur_q.pre_en ? CNT_W'(PRE_LEN) : '0;
  assign in_pre   = bitcnt_q < pre_eff;
  assign fb_full  = bitcnt_q - pre_eff;
  assign fb       = fb_full[4:0];
  assign last_bit = (bitcnt_q == pre_eff + CNT_W'(FRAME_W - 1));
  assign fw       = frame_word(cur_q);

  assign mdio_o  = busy_q && (in_pre || fw[5'd31 - fb]);
  assign mdio_oe = busy_q && (in_pre || !cur_q.rd || (fb < 5'(HDR_W)));
  assign sample  = busy_q && rise && cur_q.rd && !in_pre && (fb >= 5'(HDR_W + 2));
  assign done    = busy_q && fall && last_bit;
  assign busy    = busy_q;
  assign rdata   = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      bitcnt_q <= '0;
      shift_q  <= '0;
    end else if (!busy_q) begin
      if (launch) begin
        busy_q   <= 1'b1;
        cur_q    <= req;
        bitcnt_q <= '0;
      end
    end else begin
      if (sample) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (last_bit) busy_q <= 1'b0;
        else          bitcnt_q <= bitcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_link_monitor.sv
module mdio_link_monitor
  import mdio_ap_pkg::*;
#(
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_done,
  input  logic [DATA_W-1:0] poll_data,
  input  logic              clr_req,
  output logic              irq_sts,
  output logic              link_q,
  output logic              set_evt
);
  logic link_new;

  assign link_new = poll_data[LINK_BIT];
  assign set_evt  = poll_done && (link_new != link_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q  <= 1'b0;
      irq_sts <= 1'b0;
    end else begin
      if (set_evt) link_q <= link_new;
      if (set_evt)      irq_sts <= 1'b1;
      else if (clr_req) irq_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_autopoll_master.sv
module mdio_autopoll_master
  import mdio_ap_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int POLL_REGAD = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        irq_o
);
  logic              mode_q, pr_q, ap_en_q, sup_q, rnw_q;
  logic [2:0]        csel_q;
  logic [ADDR_W-1:0] regad_q, phyad_q;
  logic [DATA_W-1:0] data_q;
  logic              sw_pend_q, sw_run_q, poll_run_q;

  logic              ctrl_wr, ctrl_wr_ok, start_accept;
  logic              eng_busy, eng_done, sw_launch, poll_launch;
  logic              busy_bit, clr_req, irq_set, link_q, irq_sts;
  logic [DATA_W-1:0] eng_rdata;
  frame_req_t        sw_req, poll_req, eng_req;

  assign ctrl_wr      = reg_we && (reg_addr == RA_CTRL);
  assign ctrl_wr_ok   = ctrl_wr && !sw_pend_q;
  assign start_accept = ctrl_wr_ok && reg_wdata[23] && !reg_wdata[28];
  assign clr_req      = reg_we && (reg_addr == RA_IRQ) && reg_wdata[0];

  assign sw_launch   = !eng_busy && sw_pend_q && !sw_run_q;
  assign poll_launch = !eng_busy && !sw_pend_q && ap_en_q;
  assign busy_bit    = eng_busy || sw_pend_q;

  assign sw_req   = '{pre_en: !sup_q, rd: rnw_q, phyad: phyad_q, regad: regad_q,
                      wdata: data_q, csel: csel_q};
  assign poll_req = '{pre_en: !sup_q, rd: 1'b1, phyad: phyad_q,
                      regad: ADDR_W'(POLL_REGAD), wdata: '0, csel: csel_q};
  assign eng_req  = sw_launch ? sw_req : poll_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      pr_q      <= 1'b0;
      ap_en_q   <= 1'b0;
      csel_q    <= '0;
      sup_q     <= 1'b0;
      rnw_q     <= 1'b0;
      regad_q   <= '0;
      data_q    <= '0;
      sw_pend_q <= 1'b0;
    end else if (ctrl_wr_ok) begin
      mode_q    <= reg_wdata[30];
      pr_q      <= reg_wdata[29];
      ap_en_q   <= reg_wdata[28];
      csel_q    <= reg_wdata[26:24];
      sup_q     <= reg_wdata[22];
      rnw_q     <= reg_wdata[21];
      regad_q   <= reg_wdata[20:16];
      data_q    <= reg_wdata[15:0];
      sw_pend_q <= start_accept;
    end else if (eng_done && sw_run_q) begin
      sw_pend_q <= 1'b0;
      if (rnw_q) data_q <= eng_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_run_q   <= 1'b0;
      poll_run_q <= 1'b0;
      phyad_q    <= '0;
    end else begin
      if (sw_launch)     sw_run_q <= 1'b1;
      else if (eng_done) sw_run_q <= 1'b0;
      if (poll_launch)   poll_run_q <= 1'b1;
      else if (eng_done) poll_run_q <= 1'b0;
      if (reg_we && (reg_addr == RA_PHY)) phyad_q <= reg_wdata[20:16];
    end
  end

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (sw_launch || poll_launch),
    .req    (eng_req),
    .mdio_i (mdio_i),
    .mdc    (mdc_o),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .busy   (eng_busy),
    .done   (eng_done),
    .rdata  (eng_rdata)
  );

  mdio_link_monitor #(.LINK_BIT(LINK_BIT)) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .poll_done(eng_done && poll_run_q),
    .poll_data(eng_rdata),
    .clr_req  (clr_req),
    .irq_sts  (irq_sts),
    .link_q   (link_q),
    .set_evt  (irq_set)
  );

  assign irq_o = irq_sts;

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {1'b0, mode_q, pr_q, ap_en_q, busy_bit, csel_q, sw_pend_q,
                            sup_q, rnw_q, regad_q, data_q};
      RA_PHY:  reg_rdata = {11'd0, phyad_q, 16'd0};
      RA_IRQ:  reg_rdata = {30'd0, link_q, irq_sts};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mdio_ap_checker.sv
module mdio_ap_checker (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic eng_busy,
  input logic busy_bit,
  input logic start_bit,
  input logic sw_launch,
  input logic poll_launch,
  input logic ap_en,
  input logic irq,
  input logic clr_req,
  input logic irq_set
);
  p_start_holds_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit |-> busy_bit);

  p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

  p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !mdc);

  p_poll_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_launch |-> (ap_en && !start_bit));

  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_launch, poll_launch}));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);

  p_no_poll_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_en |-> !poll_launch);
endmodule

bind mdio_autopoll_master mdio_ap_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mdc        (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .eng_busy   (eng_busy),
  .busy_bit   (busy_bit),
  .start_bit  (sw_pend_q),
  .sw_launch  (sw_launch),
  .poll_launch(poll_launch),
  .ap_en      (ap_en_q),
  .irq        (irq_o),
  .clr_req    (clr_req),
  .irq_set    (irq_set)
);

// File: tb/mdio_autopoll_master_tb.sv
module mdio_autopoll_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdio_i = 1'b1;
  logic        mdc_o, mdio_o, mdio_oe, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic        cap_v  [0:63];
  logic        cap_oe [0:63];
  int          rise_t [0:63];
  int          k = 0;
  int          frame_cnt = 0;
  int          pre_len = 32;
  logic [15:0] phy_rdval = 16'h0000;
  logic        mdc_prev = 1'b0;
  logic        oe_prev = 1'b0;

  // vector: [30:28] clock select, [27] no preamble, [26] read, [25:21] PHY addr, [20:16] reg, [15:0] data
  localparam logic [30:0] VEC [0:7] = '{
    {3'd0, 1'b1, 1'b0, 5'h03, 5'h00, 16'h1234},
    {3'd1, 1'b0, 1'b1, 5'h1F, 5'h02, 16'hBEEF},
    {3'd2, 1'b1, 1'b1, 5'h00, 5'h1F, 16'h8001},
    {3'd3, 1'b0, 1'b0, 5'h15, 5'h0A, 16'hA55A},
    {3'd4, 1'b1, 1'b0, 5'h0A, 5'h15, 16'hFFFF},
    {3'd5, 1'b1, 1'b1, 5'h11, 5'h04, 16'h0000},
    {3'd6, 1'b0, 1'b1, 5'h07, 5'h1E, 16'h7FFE},
    {3'd7, 1'b1, 1'b0, 5'h1C, 5'h03, 16'h0001}
  };

  mdio_autopoll_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq_o(irq_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: records bits on MDC rise, drives read turnaround and data
  always @(negedge clk) begin
    if (mdio_oe && !oe_prev) begin
      k = 0;
      frame_cnt = frame_cnt + 1;
    end
    if (mdc_o && !mdc_prev && k < 64) begin
      cap_v[k]  = mdio_o;
      cap_oe[k] = mdio_oe;
      rise_t[k] = cyc;
      k = k + 1;
      begin
        int fb;
        fb = k - pre_len;
        if (fb == 15) mdio_i = 1'b0;
        else if (fb >= 16 && fb <= 31) mdio_i = phy_rdval[31 - fb];
        else mdio_i = 1'b1;
      end
    end
    mdc_prev = mdc_o;
    oe_prev  = mdio_oe;
  end

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd0: return 4;   3'd1: return 6;   3'd2: return 8;   3'd3: return 10;
      3'd4: return 14;  3'd5: return 20;  3'd6: return 24;  default: return 28;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input logic rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic md, input logic pr, input logic ap,
      input logic [2:0] sel, input logic st, input logic sup, input logic rd,
      input logic [4:0] ra, input logic [15:0] d);
    return {1'b0, md, pr, ap, 1'b0, sel, st, sup, rd, ra, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (!v[27]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check_frame(input string req, input logic rdf, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] d, input int pl);
    logic [31:0] w;
    int bad;
    w = exp_word(rdf, pa, ra, d);
    bad = 0;
    if (k != pl + 32) bad++;
    for (int i = 0; i < pl; i++) if (!(cap_oe[i] && cap_v[i])) bad++;
    for (int i = 0; i < 32; i++) begin
      if (rdf && i >= 14) begin
        if (cap_oe[pl + i]) bad++;
      end else if (!(cap_oe[pl + i] && cap_v[pl + i] == w[31 - i])) bad++;
    end
    chk(bad == 0, req, "frame bits mismatching", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 32'd0, "R1", "control after reset", v, 32'd0);
    rd(2'd1, v); chk(v == 32'd0, "R1", "phy addr after reset", v, 32'd0);
    rd(2'd2, v); chk(v == 32'd0, "R1", "irq word after reset", v, 32'd0);
    chk({mdc_o, mdio_oe, irq_o} == 3'b000, "R1", "mdc/oe/irq after reset",
        {29'd0, mdc_o, mdio_oe, irq_o}, 32'd0);

    // Table: R3 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic [30:0] e;
      int pl;
      e = VEC[i];
      pl = e[27] ? 0 : 32;
      pre_len = pl;
      phy_rdval = e[15:0];
      wr(2'd1, {11'd0, e[25:21], 16'd0});
      wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b0, e[30:28], 1'b1, e[27], e[26], e[20:16],
                       e[26] ? 16'h0 : e[15:0]));
      wait_idle(ok);
      chk(ok, "R2", "frame completion", 32'(ok), 32'd1);
      check_frame(e[26] ? "R4/R5/R7" : "R3/R5/R7", e[26], e[25:21], e[20:16], e[15:0], pl);
      rd(2'd0, v);
      chk(v[15:0] == e[15:0], e[26] ? "R4" : "R3", "data field after frame",
          {16'd0, v[15:0]}, {16'd0, e[15:0]});
      chk(rise_t[k-1] - rise_t[k-2] == div_of(e[30:28]), "R6", "mdc period",
          32'(rise_t[k-1] - rise_t[k-2]), 32'(div_of(e[30:28])));
      chk(mdc_o == 1'b0, "R6", "mdc idle level", {31'd0, mdc_o}, 32'd0);
    end

    // R2 start/busy during a frame, R11 writes while start set are ignored
    pre_len = 0;
    wr(2'd1, {11'd0, 5'h06, 16'd0});
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 5'h05, 16'h00F0));
    repeat (4) @(negedge clk);
    rd(2'd0, v);
    chk(v[23] && v[27], "R2", "start and busy mid-frame", {30'd0, v[23], v[27]}, 32'd3);
    wr(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 5'h09, 16'h0F0F));
    wait_idle(ok);
    rd(2'd0, v);
    chk(!v[23] && !v[27], "R2", "start and busy cleared", {30'd0, v[23], v[27]}, 32'd0);
    chk(v == mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 5'h05, 16'h00F0), "R11",
        "control after write during start", v,
        mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 5'h05, 16'h00F0));
    check_frame("R11", 1'b0, 5'h06, 5'h05, 16'h00F0, 0);

    // R12 stored mode bits, bit 31 reads zero
    wr(2'd0, 32'h8000_0000 | mk_ctrl(1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 5'h00, 16'h0000));
    rd(2'd0, v);
    chk(v[31:29] == 3'b011, "R12", "bits 31:29 readback", {29'd0, v[31:29]}, 32'd3);

    // Autopoll: R11 ignored start, R8 poll frames
    phy_rdval = 16'h0000;
    wr(2'd1, {11'd0, 5'h09, 16'd0});
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 5'h02, 16'h0000));
    rd(2'd0, v);
    chk(v[23] == 1'b0 && v[28], "R11", "start with poll enable ignored",
        {30'd0, v[28], v[23]}, 32'd2);
    begin
      int fc0;
      fc0 = frame_cnt;
      wait (frame_cnt != fc0);
      @(negedge clk);
      rd(2'd0, v);
      chk(v[27], "R8", "busy during poll", {31'd0, v[27]}, 32'd1);
      wait (k >= 14);
      begin
        logic [31:0] w;
        int bad;
        w = exp_word(1'b1, 5'h09, 5'h01, 16'h0);
        bad = 0;
        for (int i = 0; i < 14; i++) if (!(cap_oe[i] && cap_v[i] == w[31 - i])) bad++;
        chk(bad == 0, "R8", "poll frame header bits mismatching", 32'(bad), 32'd0);
      end
    end
    repeat (300) @(negedge clk);
    chk(irq_o == 1'b0, "R9", "no irq without link change", {31'd0, irq_o}, 32'd0);

    phy_rdval = 16'h0004;
    repeat (300) @(negedge clk);
    rd(2'd2, v);
    chk(v[1:0] == 2'b11 && irq_o, "R9", "link up raises irq", v, 32'd3);
    wr(2'd2, 32'd0);
    chk(irq_o == 1'b1, "R9", "write 0 leaves irq", {31'd0, irq_o}, 32'd1);
    wr(2'd2, 32'd1);
    repeat (300) @(negedge clk);
    rd(2'd2, v);
    chk(v[1:0] == 2'b10, "R9", "cleared irq stays clear", v, 32'd2);

    // R9 same-cycle set and clear: set wins
    begin
      int fc0;
      fc0 = frame_cnt;
      wait (frame_cnt != fc0);
      phy_rdval = 16'h0000;
      wait (k == 32);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd0;
      rd(2'd2, v);
      chk(v[1:0] == 2'b01, "R9", "set beats clear in same cycle", v, 32'd1);
    end

    // R10 disable while a poll is in flight
    begin
      int fc0;
      fc0 = frame_cnt;
      wait (frame_cnt != fc0);
      repeat (20) @(negedge clk);
      wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 5'h00, 16'h0000));
      rd(2'd0, v);
      chk(v[27], "R10", "busy held while draining", {31'd0, v[27]}, 32'd1);
      wait_idle(ok);
      chk(ok && k == 32, "R10", "drained frame length", 32'(k), 32'd32);
      fc0 = frame_cnt;
      repeat (300) @(negedge clk);
      chk(frame_cnt == fc0 && !mdc_o, "R10", "no frame after disable",
          32'(frame_cnt - fc0), 32'd0);
    end

    finish_run();
  end
endmodule